// File: doc/BRIEF.md
# Programmable Peripheral Bus Cycle Generator

This block takes one host read or write request and plays it out as a timed cycle on a simple external peripheral bus. The request is accepted in a single clock. The block then counts bus clocks from the start of the cycle. An address latch enable pulse and one of four data strobes are placed inside that count: memory read, memory write, I/O read or I/O write. Both pulses are placed by an offset and a width. Two timing sets exist. A hard-wired set is used for accesses flagged as on-chip. A set taken from configuration inputs is used for external devices.

Eight address regions each have a base, a size and a memory-or-I/O type, and a matching region drives its chip select for the whole cycle. External devices can hold the strobe open with a ready input. A 16-bit request is carried as one 16-bit transfer when the selected device reports 16-bit capability. Otherwise it is split into two byte cycles. A request that hits no region still completes and returns all-ones read data.

The controller sequences through four named states. IDLE waits for a request and moves to FIRST when one arrives. FIRST runs the first bus cycle. At its end it goes to SECOND when a byte split is needed, and otherwise to DONE. SECOND runs the upper-byte cycle and then goes to DONE. DONE lasts one clock, presents the read data, and returns to IDLE.

Top module: `pbus_cycle_gen`

## Requirements
- R1: After reset busy_o, done_o, wait_o, ale_o, every strobe and every chip select are low.
- R2: On an external access, clock index 0 is the first clock after acceptance. ale_o is high from index cfg_ale_off_i for cfg_ale_wid_i clocks.
- R3: The strobe is high from index cfg_stb_off_i for cfg_stb_wid_i clocks, with a width of zero treated as one. A read uses the read strobe and a write uses the write strobe. The I/O pair is used when req_io_i is 1 and the memory pair otherwise. At most one strobe is high at any time.
- R4: An access with req_internal_i=1 uses the fixed timing set: ale at index 0 for 1 clock, strobe at index 1 for 2 clocks, length 4. It asserts no chip select, ignores rdy_i, and always transfers 16 bits.
- R5: The cycle length L is the largest of cfg_len_i, the ale end (offset+width) and the strobe end. done_o is high for exactly one clock at index L plus any stretch clocks. busy_o is high from the clock after acceptance through the done clock, and nothing is driven on the bus while idle or done.
- R6: Region i hits when its type bit (1 = I/O) equals req_io_i and base <= address < base+size. The lowest-indexed hit wins. Its chip select stays high, unchanged, through every bus cycle of the access.
- R7: On an external access, each clock in which rdy_i is low during the last strobe clock stretches the strobe by one clock and delays done_o by one clock.
- R8: io16_i on I/O accesses, or mem16_i on memory accesses, is sampled in the last strobe clock. When it is high, rdata_o is bus_rdata_i. When a non-wide access hits an 8-bit device, rdata_o is {8'h00, bus_rdata_i[7:0]}.
- R9: A wide access (req_wide_i=1) to an 8-bit device runs two full byte cycles back to back. The second cycle uses address+1 and drives req_wdata_i[15:8] on bus_wdata_o[7:0]. rdata_o is {second low byte, first low byte}, and done_o comes at index 2L.
- R10: An external access that hits no region asserts no chip select, completes on time, and returns rdata_o = 16'hFFFF.
- R11: wait_o is high whenever req_valid_i is high while busy_o is high. Such a request is dropped and starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe, accepted when idle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_io_i | input | 1 | 1 = I/O space, 0 = memory space |
| req_internal_i | input | 1 | 1 = on-chip target, fixed timing |
| req_wide_i | input | 1 | 1 = 16-bit request |
| req_addr_i | input | AW | Request address |
| req_wdata_i | input | 16 | Write data |
| wait_o | output | 1 | Request refused because a cycle is running |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data, valid with done_o |
| cfg_ale_off_i | input | TW | External ale offset |
| cfg_ale_wid_i | input | TW | External ale width |
| cfg_stb_off_i | input | TW | External strobe offset |
| cfg_stb_wid_i | input | TW | External strobe width |
| cfg_len_i | input | TW | External nominal cycle length |
| rgn_base_i | input | NCS*AW | Region base addresses, region i at bits i*AW |
| rgn_size_i | input | NCS*AW | Region sizes |
| rgn_io_i | input | NCS | Region type, 1 = I/O |
| cs_o | output | NCS | Chip selects, active high |
| ale_o | output | 1 | Address latch enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| io_rd_o | output | 1 | I/O read strobe |
| io_wr_o | output | 1 | I/O write strobe |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 16 | Bus write data |
| bus_rdata_i | input | 16 | Bus read data |
| rdy_i | input | 1 | Device ready, low stretches the strobe |
| mem16_i | input | 1 | Memory device is 16-bit |
| io16_i | input | 1 | I/O device is 16-bit |

## Verification
The hardest situation to reach is a wide access to an 8-bit device whose strobe is also stretched. Here the width sample, the stretch and the change of phase all meet around the last strobe clock. The bench models an external device that answers with 8-bit or 16-bit capability and holds ready low for a chosen number of clocks once the strobe has been high for its nominal width. One access therefore drives both byte cycles through the stretch path, and the bench counts strobe pulses, stretched widths, the upper-byte lane and the done index. A second request raised in the middle of a running cycle checks that it is refused and never queued.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
    localparam int TW = 4;
    localparam int DW = 16;

    localparam logic [TW-1:0] FIX_ALE_OFF = 4'd0;
    localparam logic [TW-1:0] FIX_ALE_WID = 4'd1;
    localparam logic [TW-1:0] FIX_STB_OFF = 4'd1;
    localparam logic [TW-1:0] FIX_STB_WID = 4'd2;
    localparam logic [TW-1:0] FIX_LEN     = 4'd4;

    typedef struct packed {
        logic [TW:0] ale_on;
        logic [TW:0] ale_end;
        logic [TW:0] stb_on;
        logic [TW:0] stb_end;
        logic [TW:0] len;
    } tset_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_SECOND,
        ST_DONE
    } cyc_state_e;
endpackage

// File: rtl/pbus_timing_sel.sv
module pbus_timing_sel
    import pbus_pkg::*;
(
    input  logic          use_fixed_i,
    input  logic [TW-1:0] ale_off_i,
    input  logic [TW-1:0] ale_wid_i,
    input  logic [TW-1:0] stb_off_i,
    input  logic [TW-1:0] stb_wid_i,
    input  logic [TW-1:0] len_i,
    output tset_t         tset_o
);
    logic [TW-1:0] a_off, a_wid, s_off, s_wid, s_wid_min, c_len;
    logic [TW:0]   a_end, s_end, len_ext;

    always_comb begin
        if (use_fixed_i) begin
            a_off = FIX_ALE_OFF;
            a_wid = FIX_ALE_WID;
            s_off = FIX_STB_OFF;
            s_wid = FIX_STB_WID;
            c_len = FIX_LEN;
        end else begin
            a_off = ale_off_i;
            a_wid = ale_wid_i;
            s_off = stb_off_i;
            s_wid = stb_wid_i;
            c_len = len_i;
        end
        s_wid_min = (s_wid == '0) ? TW'(1) : s_wid;
        a_end     = {1'b0, a_off} + {1'b0, a_wid};
        s_end     = {1'b0, s_off} + {1'b0, s_wid_min};
        len_ext   = {1'b0, c_len};
        if (a_end > len_ext) len_ext = a_end;
        if (s_end > len_ext) len_ext = s_end;
        tset_o.ale_on  = {1'b0, a_off};
        tset_o.ale_end = a_end;
        tset_o.stb_on  = {1'b0, s_off};
        tset_o.stb_end = s_end;
        tset_o.len     = len_ext;
    end
endmodule

// File: rtl/pbus_region_decode.sv
module pbus_region_decode #(
    parameter int NCS = 8,
    parameter int AW  = 16
) (
    input  logic [AW-1:0]     addr_i,
    input  logic              is_io_i,
    input  logic [NCS*AW-1:0] base_i,
    input  logic [NCS*AW-1:0] size_i,
    input  logic [NCS-1:0]    io_i,
    output logic [NCS-1:0]    sel_o,
    output logic              hit_o
);
    logic [NCS-1:0] raw;

    for (genvar g = 0; g < NCS; g++) begin : g_cmp
        logic [AW-1:0] base_w, size_w, dist_w;
        assign base_w = base_i[g*AW +: AW];
        assign size_w = size_i[g*AW +: AW];
        assign dist_w = addr_i - base_w;
        assign raw[g] = (io_i[g] == is_io_i) && (addr_i >= base_w) && (dist_w < size_w);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        sel_o = '0;
        for (int i = 0; i < NCS; i++) begin
            if (raw[i] && !found) begin
                sel_o[i] = 1'b1;
                found    = 1'b1;
            end
        end
        hit_o = found;
    end
endmodule

// File: rtl/pbus_cycle_gen.sv
module pbus_cycle_gen
    import pbus_pkg::*;
#(
    parameter int NCS = 8,
    parameter int AW  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic              req_io_i,
    input  logic              req_internal_i,
    input  logic              req_wide_i,
    input  logic [AW-1:0]     req_addr_i,
    input  logic [DW-1:0]     req_wdata_i,
    output logic              wait_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DW-1:0]     rdata_o,
    input  logic [TW-1:0]     cfg_ale_off_i,
    input  logic [TW-1:0]     cfg_ale_wid_i,
    input  logic [TW-1:0]     cfg_stb_off_i,
    input  logic [TW-1:0]     cfg_stb_wid_i,
    input  logic [TW-1:0]     cfg_len_i,
    input  logic [NCS*AW-1:0] rgn_base_i,
    input  logic [NCS*AW-1:0] rgn_size_i,
    input  logic [NCS-1:0]    rgn_io_i,
    output logic [NCS-1:0]    cs_o,
    output logic              ale_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic              io_rd_o,
    output logic              io_wr_o,
    output logic [AW-1:0]     bus_addr_o,
    output logic [DW-1:0]     bus_wdata_o,
    input  logic [DW-1:0]     bus_rdata_i,
    input  logic              rdy_i,
    input  logic              mem16_i,
    input  logic              io16_i
);
    localparam int BW = DW / 2;

    cyc_state_e     state_q, state_d;
    tset_t          tset_w, tset_q;
    logic [NCS-1:0] sel_w, sel_q;
    logic           hit_w, hit_q;
    logic [TW:0]    cnt_q;
    logic           wr_q, io_q, int_q, wide_q, dev16_q;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  wdata_q, lo_q;
    logic [BW-1:0]  hi_q;
    logic           run, ale_act, stb_act, last_stb, stall, endc;
    logic           dev16_now, dev16_eff, split_need, accept;

    pbus_timing_sel u_tsel (
        .use_fixed_i (req_internal_i),
        .ale_off_i   (cfg_ale_off_i),
        .ale_wid_i   (cfg_ale_wid_i),
        .stb_off_i   (cfg_stb_off_i),
        .stb_wid_i   (cfg_stb_wid_i),
        .len_i       (cfg_len_i),
        .tset_o      (tset_w)
    );

    pbus_region_decode #(.NCS(NCS), .AW(AW)) u_rdec (
        .addr_i  (req_addr_i),
        .is_io_i (req_io_i),
        .base_i  (rgn_base_i),
        .size_i  (rgn_size_i),
        .io_i    (rgn_io_i),
        .sel_o   (sel_w),
        .hit_o   (hit_w)
    );

    // cycle timing terms
    assign accept     = (state_q == ST_IDLE) && req_valid_i;
    assign run        = (state_q == ST_FIRST) || (state_q == ST_SECOND);
    assign ale_act    = (cnt_q >= tset_q.ale_on) && (cnt_q < tset_q.ale_end);
    assign stb_act    = (cnt_q >= tset_q.stb_on) && (cnt_q < tset_q.stb_end);
    assign last_stb   = run && (cnt_q == tset_q.stb_end - 1'b1);
    assign stall      = last_stb && !int_q && !rdy_i;
    assign endc       = run && (cnt_q == tset_q.len - 1'b1) && !stall;
    assign dev16_now  = io_q ? io16_i : mem16_i;
    assign dev16_eff  = last_stb ? dev16_now : dev16_q;
    assign split_need = wide_q && !int_q && hit_q && !dev16_eff;

    // next-state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid_i) state_d = ST_FIRST;
            ST_FIRST:  if (endc) state_d = split_need ? ST_SECOND : ST_DONE;
            ST_SECOND: if (endc) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            tset_q  <= '0;
            sel_q   <= '0;
            hit_q   <= 1'b0;
            wr_q    <= 1'b0;
            io_q    <= 1'b0;
            int_q   <= 1'b0;
            wide_q  <= 1'b0;
            dev16_q <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else if (accept) begin
            cnt_q   <= '0;
            tset_q  <= tset_w;
            sel_q   <= sel_w;
            hit_q   <= hit_w;
            wr_q    <= req_write_i;
            io_q    <= req_io_i;
            int_q   <= req_internal_i;
            wide_q  <= req_wide_i;
            dev16_q <= 1'b0;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
        end else if (run) begin
            if (endc)        cnt_q <= '0;
            else if (!stall) cnt_q <= cnt_q + 1'b1;
            if (last_stb && !stall) begin
                if (state_q == ST_FIRST) begin
                    dev16_q <= dev16_now;
                    lo_q    <= bus_rdata_i;
                end else begin
                    hi_q    <= bus_rdata_i[BW-1:0];
                end
            end
        end
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        done_o      = (state_q == ST_DONE);
        wait_o      = req_valid_i && busy_o;
        cs_o        = (run && hit_q && !int_q) ? sel_q : '0;
        ale_o       = run && ale_act;
        mem_rd_o    = run && stb_act && !wr_q && !io_q;
        mem_wr_o    = run && stb_act &&  wr_q && !io_q;
        io_rd_o     = run && stb_act && !wr_q &&  io_q;
        io_wr_o     = run && stb_act &&  wr_q &&  io_q;
        bus_addr_o  = addr_q + AW'(state_q == ST_SECOND);
        bus_wdata_o = (state_q == ST_SECOND) ? {wdata_q[DW-1:BW], wdata_q[DW-1:BW]} : wdata_q;
        if (!int_q && !hit_q)     rdata_o = '1;
        else if (int_q || dev16_q) rdata_o = lo_q;
        else if (wide_q)          rdata_o = {hi_q, lo_q[BW-1:0]};
        else                      rdata_o = {{BW{1'b0}}, lo_q[BW-1:0]};
    end
endmodule

// File: rtl/pbus_cycle_gen_chk.sv
module pbus_cycle_gen_chk #(
    parameter int NCS = 8
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic           req_valid_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [NCS-1:0] cs_o,
    input logic           ale_o,
    input logic           mem_rd_o,
    input logic           mem_wr_o,
    input logic           io_rd_o,
    input logic           io_wr_o
);
    AST_CS_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(cs_o)); // R6
    AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones({mem_rd_o, mem_wr_o, io_rd_o, io_wr_o}) <= 1); // R3
    AST_QUIET_OFF_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o || done_o) |-> (cs_o == '0 && !ale_o && !mem_rd_o && !mem_wr_o && !io_rd_o && !io_wr_o)); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R5
    AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && req_valid_i) |=> busy_o); // R5
    AST_CS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && !done_o && $past(busy_o && !done_o)) |-> $stable(cs_o)); // R6
endmodule

bind pbus_cycle_gen pbus_cycle_gen_chk #(.NCS(NCS)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cs_o        (cs_o),
    .ale_o       (ale_o),
    .mem_rd_o    (mem_rd_o),
    .mem_wr_o    (mem_wr_o),
    .io_rd_o     (io_rd_o),
    .io_wr_o     (io_wr_o)
);

// File: tb/tb_pbus_cycle_gen.sv
module tb_pbus_cycle_gen;
    localparam int NCS = 8;
    localparam int AW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 0, req_write = 0, req_io = 0, req_internal = 0, req_wide = 0;
    logic [AW-1:0]   req_addr = '0;
    logic [15:0]     req_wdata = '0;
    logic            wait_w, busy_w, done_w;
    logic [15:0]     rdata_w;
    logic [3:0]      c_ale_off, c_ale_wid, c_stb_off, c_stb_wid, c_len;
    logic [NCS*AW-1:0] r_base, r_size;
    logic [NCS-1:0]  r_io;
    logic [NCS-1:0]  cs_w;
    logic            ale_w, mrd_w, mwr_w, iord_w, iowr_w;
    logic [AW-1:0]   baddr_w;
    logic [15:0]     bwdata_w, brdata_w;
    logic            rdy = 1'b1, dev16 = 1'b0, dev_sig;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign dev_sig  = dev16 && (|cs_w);
    assign brdata_w = {~baddr_w[7:0], baddr_w[7:0]};

    pbus_cycle_gen #(.NCS(NCS), .AW(AW)) dut (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_io_i(req_io),
        .req_internal_i(req_internal), .req_wide_i(req_wide),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata),
        .wait_o(wait_w), .busy_o(busy_w), .done_o(done_w), .rdata_o(rdata_w),
        .cfg_ale_off_i(c_ale_off), .cfg_ale_wid_i(c_ale_wid),
        .cfg_stb_off_i(c_stb_off), .cfg_stb_wid_i(c_stb_wid), .cfg_len_i(c_len),
        .rgn_base_i(r_base), .rgn_size_i(r_size), .rgn_io_i(r_io),
        .cs_o(cs_w), .ale_o(ale_w), .mem_rd_o(mrd_w), .mem_wr_o(mwr_w),
        .io_rd_o(iord_w), .io_wr_o(iowr_w),
        .bus_addr_o(baddr_w), .bus_wdata_o(bwdata_w), .bus_rdata_i(brdata_w),
        .rdy_i(rdy), .mem16_i(dev_sig), .io16_i(dev_sig)
    );

    // observed values of the last access
    int ob_ale_first, ob_ale_cnt, ob_stb_first, ob_stb_cnt, ob_stb_rises, ob_done;
    logic [NCS-1:0] ob_cs;
    logic [3:0]     ob_kind;
    logic [15:0]    ob_rdata;
    logic [7:0]     ob_wlane;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input bit io, input bit intl, input bit wide,
                          input logic [15:0] addr, input logic [15:0] wd,
                          input bit d16, input int base_w, input int extra);
        bit ps = 0;
        int s = 0;
        ob_ale_first = -1; ob_ale_cnt = 0; ob_stb_first = -1; ob_stb_cnt = 0;
        ob_stb_rises = 0; ob_done = -1; ob_cs = '0; ob_kind = '0; ob_rdata = '0; ob_wlane = '0;
        dev16 = d16;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_io = io; req_internal = intl;
        req_wide = wide; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 80; k++) begin
            bit st;
            #1;
            st = mrd_w | mwr_w | iord_w | iowr_w;
            if (ale_w) begin
                if (ob_ale_first < 0) ob_ale_first = k;
                ob_ale_cnt++;
            end
            if (st) begin
                if (!ps) begin ob_stb_rises++; s = 0; end
                if (ob_stb_first < 0) ob_stb_first = k;
                s++;
                ob_stb_cnt++;
                ob_wlane = bwdata_w[7:0];
            end
            ps = st;
            ob_cs   = ob_cs | cs_w;
            ob_kind = ob_kind | {iowr_w, iord_w, mwr_w, mrd_w};
            rdy = !(st && s >= base_w && s < base_w + extra);
            if (done_w) begin
                ob_done  = k;
                ob_rdata = rdata_w;
                break;
            end
            @(negedge clk);
        end
        rdy = 1;
    endtask

    task automatic set_cfg_a();
        c_ale_off = 4'd2; c_ale_wid = 4'd2; c_stb_off = 4'd3; c_stb_wid = 4'd3; c_len = 4'd8;
    endtask

    task automatic t_reset();
        #1;
        chk("R1 busy", busy_w, 0);
        chk("R1 done", done_w, 0);
        chk("R1 wait", wait_w, 0);
        chk("R1 cs", cs_w, 0);
        chk("R1 strobes", {ale_w, mrd_w, mwr_w, iord_w, iowr_w}, 0);
    endtask

    task automatic t_ext_read16();
        set_cfg_a();
        access(0, 0, 0, 1, 16'h4004, 16'h0, 1, 3, 0);
        chk("R2 ale first", ob_ale_first, 2);
        chk("R2 ale width", ob_ale_cnt, 2);
        chk("R3 stb first", ob_stb_first, 3);
        chk("R3 stb width", ob_stb_cnt, 3);
        chk("R3 mem read strobe", ob_kind, 4'b0001);
        chk("R5 done index", ob_done, 8);
        chk("R6 cs region3", ob_cs, 8'h08);
        chk("R8 16-bit rdata", ob_rdata, 16'hFB04);
    endtask

    task automatic t_internal();
        set_cfg_a();
        access(0, 0, 1, 0, 16'h0020, 16'h0, 0, 2, 5);
        chk("R4 ale first", ob_ale_first, 0);
        chk("R4 ale width", ob_ale_cnt, 1);
        chk("R4 stb first", ob_stb_first, 1);
        chk("R4 stb width ignores rdy", ob_stb_cnt, 2);
        chk("R4 done index", ob_done, 4);
        chk("R4 no cs", ob_cs, 0);
        chk("R4 16-bit rdata", ob_rdata, 16'hDF20);
    endtask

    task automatic t_stretch();
        set_cfg_a();
        access(0, 0, 0, 0, 16'h4004, 16'h0, 1, 3, 3);
        chk("R7 stretched strobe", ob_stb_cnt, 6);
        chk("R7 delayed done", ob_done, 11);
    endtask

    task automatic t_len_ext();
        set_cfg_a();
        c_len = 4'd2;
        access(0, 0, 0, 0, 16'h4004, 16'h0, 1, 3, 0);
        chk("R5 extended length done", ob_done, 6);
        c_stb_wid = 4'd0;
        access(0, 0, 0, 0, 16'h4004, 16'h0, 1, 1, 0);
        chk("R3 zero width as one", ob_stb_cnt, 1);
        chk("R5 length with min width", ob_done, 4);
        set_cfg_a();
    endtask

    task automatic t_nomatch();
        set_cfg_a();
        access(0, 0, 0, 1, 16'h8000, 16'h0, 1, 3, 0);
        chk("R10 no cs", ob_cs, 0);
        chk("R10 all-ones rdata", ob_rdata, 16'hFFFF);
        chk("R10 done on time", ob_done, 8);
        access(0, 1, 0, 0, 16'h4004, 16'h0, 1, 3, 0);
        chk("R6 type mismatch no cs", ob_cs, 0);
        chk("R10 mismatch rdata", ob_rdata, 16'hFFFF);
    endtask

    task automatic t_split_read();
        set_cfg_a();
        access(0, 0, 0, 1, 16'h1090, 16'h0, 0, 3, 2);
        chk("R6 priority lowest region", ob_cs, 8'h01);
        chk("R9 two byte cycles", ob_stb_rises, 2);
        chk("R7 R9 both stretched", ob_stb_cnt, 10);
        chk("R9 split done", ob_done, 20);
        chk("R9 assembled rdata", ob_rdata, 16'h9190);
        access(0, 0, 0, 0, 16'h1020, 16'h0, 0, 3, 0);
        chk("R8 narrow rdata", ob_rdata, 16'h0020);
        chk("R8 narrow single cycle", ob_stb_rises, 1);
    endtask

    task automatic t_split_write();
        set_cfg_a();
        access(1, 1, 0, 1, 16'h0304, 16'hA55A, 0, 3, 0);
        chk("R3 io write strobe", ob_kind, 4'b1000);
        chk("R9 write two cycles", ob_stb_rises, 2);
        chk("R9 upper byte on low lane", ob_wlane, 8'hA5);
        chk("R9 write done", ob_done, 16);
        chk("R6 io region cs", ob_cs, 8'h04);
    endtask

    task automatic t_wait();
        set_cfg_a();
        dev16 = 1;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_io = 0; req_internal = 0; req_wide = 0; req_addr = 16'h4004;
        @(negedge clk);
        req_valid = 0;
        repeat (3) @(negedge clk);
        req_valid = 1; req_addr = 16'h1000;
        #1;
        chk("R11 wait while busy", wait_w, 1);
        while (!done_w) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        #1;
        chk("R11 dropped request idle", busy_w, 0);
        @(negedge clk); #1;
        chk("R11 no late cycle", busy_w, 0);
        chk("R11 wait low when idle", wait_w, 0);
    endtask

    initial begin
        set_cfg_a();
        r_base = '0; r_size = '0; r_io = '0;
        r_base[0*AW +: AW] = 16'h1000; r_size[0*AW +: AW] = 16'h0100;
        r_base[1*AW +: AW] = 16'h1080; r_size[1*AW +: AW] = 16'h0100;
        r_base[2*AW +: AW] = 16'h0300; r_size[2*AW +: AW] = 16'h0010; r_io[2] = 1'b1;
        r_base[3*AW +: AW] = 16'h4000; r_size[3*AW +: AW] = 16'h0010;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_ext_read16();
        t_internal();
        t_stretch();
        t_len_ext();
        t_nomatch();
        t_split_read();
        t_split_write();
        t_wait();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R5 actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule